// File: doc/BRIEF.md
# Index/Data Configuration Register Port

This block is a byte-wide configuration register file reached through a window of two I/O addresses. A write to the lower address latches an index. An access to the upper address reads or writes the register that the index selects. Only the top 32 indices (0xE0 to 0xFF) hold storage, and a fixed, irregular write-protect map leaves half of them read-only. Indices below 0xE0 read as zero and ignore writes.

The whole window is switched by a single enable input, which a host bridge drives from one bit of its own configuration space. While that input is low, the block accepts no writes at either address and does not drive read data. Two of the writable registers hold relocation values for a serial port. Writing any value other than their reset value is stored as normal, but it also sets a sticky flag on a side output. A later stage can read that flag to learn that an unsupported relocation was requested.

Top module: `cfg_window_port`

## Requirements
- R1: After reset the index is 0x00 and the relocation flag is low. Register 0xE0 holds 0x3C, 0xE2 holds 0x03, 0xE3 holds 0xFC, 0xE6 holds 0xDE, 0xE7 holds 0xFE and 0xE8 holds 0xBE. Every other index reads 0x00.
- R2: A write strobe at address BASE_ADDR (0x3F0) with the window enabled loads io_wdata as the index on that clock edge. A read at BASE_ADDR returns the current index.
- R3: A read strobe at BASE_ADDR+1 (0x3F1) with the window enabled returns the selected register in the same cycle, with io_rdata_oe high. io_rdata_oe is never high without io_rd and win_en.
- R4: A data write to a writable index is stored on the clock edge of the write strobe. The writable indices are 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R5: A data write to any other index has no effect. This covers 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB and 0xFD–0xFF.
- R6: While win_en is low, writes to either address change neither the index nor any register, io_rdata_oe stays low and io_rdata reads 0xFF.
- R7: When io_rdata_oe is low, io_rdata is 0xFF. This holds for a read of any other address and for a cycle with no read strobe. Writes to other addresses have no effect.
- R8: A data write of a value other than 0xFE to index 0xE7, or other than 0xBE to index 0xE8, sets reloc_flag on that edge. The value is still stored. Writing the reset value does not set the flag. The flag clears only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W (16) | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| win_en | input | 1 | Window enable from the bridge configuration bit |
| io_rdata | output | 8 | Read data, 0xFF when not driven |
| io_rdata_oe | output | 1 | High while the block drives read data |
| reloc_flag | output | 1 | Sticky unsupported-relocation flag |

## Verification
A wrong index shows up on the first read of either address after the bad write, because the index reads back directly and it also selects the data returned. A wrong protect-map entry or reset value appears in the same-cycle readback of that index, so the bench sweeps all 256 indices, both after reset and after a write pass. A leak through the disabled window shows up once the window is enabled again: the index or register readback differs from the value held before.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    typedef struct packed {
        logic [7:0] idx;
        logic       reloc;
    } cfgwin_ctl_t;

    // Protect map: only a sparse subset of the top 32 indices accepts writes.
    function automatic logic idx_writable(input logic [7:0] i);
        logic ro;
        ro = (i inside {8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3, 8'hF5, 8'hF7,
                        [8'hF9:8'hFB], [8'hFD:8'hFF]});
        return (i >= 8'hE0) && !ro;
    endfunction

    function automatic logic [7:0] idx_default(input logic [7:0] i);
        case (i)
            8'hE0:   return 8'h3C;
            8'hE2:   return 8'h03;
            8'hE3:   return 8'hFC;
            8'hE6:   return 8'hDE;
            8'hE7:   return 8'hFE;
            8'hE8:   return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    // Relocation registers: a value other than the default is flagged.
    function automatic logic idx_is_reloc(input logic [7:0] i);
        return (i == 8'hE7) || (i == 8'hE8);
    endfunction

endpackage

// File: rtl/cfgwin_dec.sv
module cfgwin_dec #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_en,
    input  logic              wr,
    input  logic              rd,
    output logic              idx_wr,
    output logic              dat_wr,
    output logic              idx_rd,
    output logic              dat_rd
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

    logic hit_idx, hit_dat;

    always_comb begin
        hit_idx = win_en && (addr == BASE_ADDR);
        hit_dat = win_en && (addr == DATA_ADDR);
        idx_wr  = wr && hit_idx;
        dat_wr  = wr && hit_dat;
        idx_rd  = rd && hit_idx;
        dat_rd  = rd && hit_dat;
    end
endmodule

// File: rtl/cfgwin_wprot.sv
module cfgwin_wprot
    import cfgwin_pkg::*;
(
    input  logic       dat_wr,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic       reg_we,
    output logic       reloc_hit
);
    always_comb begin
        reg_we    = dat_wr && idx_writable(idx);
        reloc_hit = reg_we && idx_is_reloc(idx) && (wdata != idx_default(idx));
    end
endmodule

// File: rtl/cfgwin_regbank.sv
module cfgwin_regbank
    import cfgwin_pkg::*;
#(
    parameter int WIN_LO = 224
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int NREGS = 256 - WIN_LO;

    logic [7:0] ent_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_ent
        localparam logic [7:0] MY_IDX = 8'(WIN_LO + g);
        localparam logic [7:0] RST_V  = idx_default(MY_IDX);
        logic [7:0] ent_d;

        always_comb begin
            ent_d = ent_q[g];
            if (we && (idx == MY_IDX)) begin
                ent_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[g] <= RST_V;
            end else begin
                ent_q[g] <= ent_d;
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int k = 0; k < NREGS; k++) begin
            if (idx == 8'(WIN_LO + k)) begin
                rdata = ent_q[k];
            end
        end
    end
endmodule

// File: rtl/cfg_window_port.sv
module cfg_window_port
    import cfgwin_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
    parameter int                WIN_LO    = 224
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    input  logic              win_en,
    output logic [7:0]        io_rdata,
    output logic              io_rdata_oe,
    output logic              reloc_flag
);
    cfgwin_ctl_t st_d, st_q;

    logic       idx_wr, dat_wr, idx_rd, dat_rd;
    logic       reg_we, reloc_hit;
    logic [7:0] bank_rd;
    logic [7:0] idx_cur;

    cfgwin_dec #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .addr   (io_addr),
        .win_en (win_en),
        .wr     (io_wr),
        .rd     (io_rd),
        .idx_wr (idx_wr),
        .dat_wr (dat_wr),
        .idx_rd (idx_rd),
        .dat_rd (dat_rd)
    );

    cfgwin_wprot u_wprot (
        .dat_wr    (dat_wr),
        .idx       (st_q.idx),
        .wdata     (io_wdata),
        .reg_we    (reg_we),
        .reloc_hit (reloc_hit)
    );

    cfgwin_regbank #(
        .WIN_LO (WIN_LO)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .idx   (st_q.idx),
        .wdata (io_wdata),
        .rdata (bank_rd)
    );

    always_comb begin
        st_d = st_q;
        if (idx_wr) begin
            st_d.idx = io_wdata;
        end
        if (reloc_hit) begin
            st_d.reloc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        idx_cur     = st_q.idx;
        reloc_flag  = st_q.reloc;
        io_rdata_oe = idx_rd || dat_rd;
        if (idx_rd) begin
            io_rdata = st_q.idx;
        end else if (dat_rd) begin
            io_rdata = bank_rd;
        end else begin
            io_rdata = 8'hFF;
        end
    end
endmodule

// File: rtl/cfg_window_port_chk.sv
module cfg_window_port_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic              win_en,
    input logic [7:0]        io_rdata,
    input logic              io_rdata_oe,
    input logic              reloc_flag,
    input logic [7:0]        idx_cur
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

    // R6
    win_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> (!io_rdata_oe && io_rdata == 8'hFF));

    // R6
    win_off_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |=> $stable(idx_cur));

    // R7
    undriven_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rdata_oe |-> io_rdata == 8'hFF);

    // R3
    oe_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_oe |-> (io_rd && win_en));

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && win_en && io_addr == BASE_ADDR) |=> idx_cur == $past(io_wdata));

    // R8
    reloc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_flag |=> reloc_flag);

    // R8
    reloc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reloc_flag) |-> $past(io_wr && win_en && io_addr == DATA_ADDR &&
                                    (idx_cur == 8'hE7 || idx_cur == 8'hE8)));
endmodule

bind cfg_window_port cfg_window_port_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_wr       (io_wr),
    .io_rd       (io_rd),
    .io_wdata    (io_wdata),
    .win_en      (win_en),
    .io_rdata    (io_rdata),
    .io_rdata_oe (io_rdata_oe),
    .reloc_flag  (reloc_flag),
    .idx_cur     (idx_cur)
);

// File: tb/sim_cfg_window_port.sv
module sim_cfg_window_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        win_en = 1'b1;
    logic [7:0]  io_rdata;
    logic        io_rdata_oe;
    logic        reloc_flag;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    always #2 clk = ~clk;

    cfg_window_port u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .win_en(win_en), .io_rdata(io_rdata),
        .io_rdata_oe(io_rdata_oe), .reloc_flag(reloc_flag)
    );

    function automatic bit can_write(input int i);
        if (i < 224) return 0;
        case (i)
            228, 229, 243, 245, 247: return 0;
            default: ;
        endcase
        if (i >= 233 && i <= 237) return 0;
        if (i >= 249 && i <= 251) return 0;
        if (i >= 253) return 0;
        return 1;
    endfunction

    function automatic logic [7:0] rst_val(input int i);
        case (i)
            224: return 8'h3C;
            226: return 8'h03;
            227: return 8'hFC;
            230: return 8'hDE;
            231: return 8'hFE;
            232: return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        d = io_rdata; oe = io_rdata_oe;
        io_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        logic       oe;
        logic [7:0] pat;
        for (int i = 0; i < 256; i++) model[i] = rst_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 flag", {7'd0, reloc_flag}, 8'h00);
        io_read(16'h03F0, rd, oe);
        check("R1 index", rd, 8'h00);
        check("R2 oe idx", {7'd0, oe}, 8'h01);

        // R1/R2/R3 sweep of reset values
        for (int i = 0; i < 256; i++) begin
            io_write(16'h03F0, 8'(i));
            io_read(16'h03F0, rd, oe);
            check("R2 index readback", rd, 8'(i));
            io_read(16'h03F1, rd, oe);
            check("R1 default", rd, model[i]);
            check("R3 oe", {7'd0, oe}, 8'h01);
        end

        // R8 relocation flag
        io_write(16'h03F0, 8'hE7);
        io_write(16'h03F1, 8'hFE);
        #1 check("R8 E7 default no flag", {7'd0, reloc_flag}, 8'h00);
        io_write(16'h03F0, 8'hE8);
        io_write(16'h03F1, 8'hBE);
        #1 check("R8 E8 default no flag", {7'd0, reloc_flag}, 8'h00);
        io_write(16'h03F1, 8'h11);
        #1 check("R8 flag set", {7'd0, reloc_flag}, 8'h01);
        io_read(16'h03F1, rd, oe);
        check("R8 value stored", rd, 8'h11);
        io_write(16'h03F1, 8'hBE);
        #1 check("R8 sticky", {7'd0, reloc_flag}, 8'h01);
        model[232] = 8'hBE;

        // R4/R5 write sweep
        for (int i = 0; i < 256; i++) begin
            pat = 8'(i) ^ 8'h5A;
            io_write(16'h03F0, 8'(i));
            io_write(16'h03F1, pat);
            if (can_write(i)) model[i] = pat;
            io_read(16'h03F1, rd, oe);
            check(can_write(i) ? "R4 stored" : "R5 ignored", rd, model[i]);
        end

        // R6 window disabled
        io_write(16'h03F0, 8'hE1);
        win_en = 1'b0;
        io_read(16'h03F0, rd, oe);
        check("R6 idx rd ff", rd, 8'hFF);
        check("R6 idx oe", {7'd0, oe}, 8'h00);
        io_read(16'h03F1, rd, oe);
        check("R6 dat rd ff", rd, 8'hFF);
        check("R6 dat oe", {7'd0, oe}, 8'h00);
        io_write(16'h03F1, 8'h77);
        io_write(16'h03F0, 8'hE2);
        @(negedge clk);
        win_en = 1'b1;
        io_read(16'h03F0, rd, oe);
        check("R6 index held", rd, 8'hE1);
        io_read(16'h03F1, rd, oe);
        check("R6 reg held", rd, model[225]);

        // R7 unmapped addresses and no strobe
        io_read(16'h03F2, rd, oe);
        check("R7 unmapped rd", rd, 8'hFF);
        check("R7 unmapped oe", {7'd0, oe}, 8'h00);
        io_read(16'h02F1, rd, oe);
        check("R7 alias rd", rd, 8'hFF);
        @(negedge clk);
        io_addr = 16'h03F1; #1;
        check("R7 no strobe", io_rdata, 8'hFF);
        check("R7 no strobe oe", {7'd0, io_rdata_oe}, 8'h00);
        io_write(16'h03F2, 8'hE3);
        io_write(16'h02F1, 8'h99);
        io_read(16'h03F0, rd, oe);
        check("R7 index untouched", rd, 8'hE1);
        io_read(16'h03F1, rd, oe);
        check("R7 reg untouched", rd, model[225]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule